// File: doc/BRIEF.md
# UART Processor-Side Register File

This block is the part of a programmable UART that faces an 8-bit bidirectional processor bus. It qualifies each access with a three-way chip select, splits the access by a register-select input and a read/write input, and acts on writes once per rising edge of a timing strobe. Writes go either to the transmit holding register or to the control register. Reads return either the receive holding register or the status register. The read path is combinational whenever the block is selected for a read.

The serial transmit and receive engines are outside the block. The transmit engine sees the held byte and a full flag, and it answers with a take pulse and a shift-empty level. The receive engine delivers each byte with a valid pulse and its error flags. From the control register the block drives the character format to both engines. It also drives an active-low request-to-send line, an active-low interrupt line and the serial output. A break setting can force the serial output low, and clear forces it high.

A control write with bit 7 high sets only the transmit request bit. Software therefore loads the format with one write and then raises the request with a second write.

Top module: `uart_cpu_regs`

## Requirements
- R1: An access takes effect only while all three chip-select inputs are high. A strobe with any select low changes no register, and a read with any select low drives the read bus to 0x00.
- R2: With register select low, a write loads the transmit holding register, and a read returns the receive holding register. At most one of the four access events (holding write, control write, receive read, status read) occurs in any cycle.
- R3: A control write with bit 7 low loads the whole format and clears transmit request. Bits [1:0] give the word length code, reported as 5 plus the code data bits. Bit 2 enables parity, bit 3 selects even parity, bit 4 selects two stop bits, bit 5 is break and bit 6 enables the receive interrupt.
- R4: A control write with bit 7 high sets transmit request and leaves bits [6:0] of the control register unchanged.
- R5: Request-to-send is low one cycle after transmit request is set, and it returns high one cycle after a control write with bit 7 low.
- R6: With register select high, a read returns the status byte. Bit 0 is receive ready, bit 1 overrun, bit 2 parity error, bit 3 framing error, bits [5:4] read 0, bit 6 is holding register empty and bit 7 is the shift-empty input.
- R7: Only the first clock of a strobe high period is a bus access. Data presented while the strobe stays high is not taken.
- R8: While clear is low, the serial output is high. Clear resets the control register, the status flags and the receive holding register to zero, marks the holding register empty and releases the interrupt.
- R9: The serial output is low while break is set. Otherwise it follows the transmit engine's serial line.
- R10: A received byte loads the receive holding register and sets ready, and a receive read clears ready. A byte that arrives while ready is set and no receive read happens in the same cycle sets overrun, which a status read clears. Parity and framing flags follow the most recent byte. A byte that arrives in the same cycle as a receive read leaves ready set and sets no overrun.
- R11: The interrupt output goes low one cycle after any of these events: a byte arrives with the receive interrupt enabled; the holding register empties while transmit request is set; transmit request is set while the holding register is empty; the shift-empty input rises while the holding register is empty and transmit request is set. A status read or a holding write releases the interrupt, but a new event in the same cycle keeps it asserted.
- R12: A holding write sets the full flag and presents the byte to the transmit engine, and a take pulse clears the flag. If a take and a holding write fall in the same cycle, the flag stays set and the new byte is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| clear_n | input | 1 | Asynchronous clear, active low |
| cs | input | CS_N | Chip selects, all high to select |
| reg_sel | input | 1 | 0: holding registers, 1: control/status |
| rd_wr | input | 1 | 1: read, 0: write |
| strobe | input | 1 | Timing strobe, rising edge qualifies an access |
| wdata | input | 8 | Transmit bus, write data |
| rdata | output | 8 | Receive bus, read data |
| thr_data | output | 8 | Byte held for the transmit engine |
| thr_full | output | 1 | Holding register contains a byte |
| tx_take | input | 1 | Transmit engine took the held byte |
| tx_shift_empty | input | 1 | Transmit shift register is empty |
| tx_serial | input | 1 | Serial line from the transmit engine |
| rx_valid | input | 1 | Receive engine delivers a byte |
| rx_byte | input | 8 | Received byte |
| rx_perr | input | 1 | Parity error of the delivered byte |
| rx_ferr | input | 1 | Framing error of the delivered byte |
| data_bits | output | 4 | Data bits per character, 5 to 8 |
| par_en | output | 1 | Parity enabled |
| par_even | output | 1 | Even parity selected |
| two_stop | output | 1 | Two stop bits selected |
| rts_n | output | 1 | Request to send, active low |
| irq_n | output | 1 | Interrupt, active low |
| sdo | output | 1 | Serial data output |

## Verification
Two pairs of events can coincide and are driven in the same cycle on purpose. A receive delivery can land on the cycle of a receive read. The bench checks that the read returns the old byte, ready stays set and no overrun appears. A receive delivery can also land on the cycle of a status read. The bench checks that the interrupt is still low afterwards, because setting takes precedence over release. On the transmit side, a take pulse is driven in the same cycle as a holding write. The bench checks that the full flag survives and that the new byte is the one held.

// File: rtl/uart_reg_pkg.sv
package uart_reg_pkg;

  localparam int BUS_W = 8;

  // control byte layout: bit 7 is the request, the rest is format
  typedef struct packed {
    logic       tx_req;
    logic       rx_irq_en;
    logic       brk;
    logic       two_stop;
    logic       par_even;
    logic       par_en;
    logic [1:0] wlen;
  } ctrl_t;

  typedef struct packed {
    logic       shift_empty;
    logic       thr_empty;
    logic [1:0] zero;
    logic       ferr;
    logic       perr;
    logic       ovr;
    logic       rdy;
  } stat_t;

  // next control value after a control write of byte d
  function automatic ctrl_t ctrl_after_write(ctrl_t cur, logic [BUS_W-1:0] d);
    ctrl_t r;
    if (d[BUS_W-1]) begin
      r        = cur;
      r.tx_req = 1'b1;
    end else begin
      r = ctrl_t'(d);
    end
    return r;
  endfunction

  function automatic logic [3:0] data_bits_of(logic [1:0] code);
    return 4'd5 + {2'b00, code};
  endfunction

endpackage

// File: rtl/uart_bus_decode.sv
module uart_bus_decode #(
  parameter int CS_N = 3
) (
  input  logic            clk,
  input  logic            clear_n,
  input  logic [CS_N-1:0] cs,
  input  logic            reg_sel,
  input  logic            rd_wr,
  input  logic            strobe,
  output logic            selected,
  output logic            rd_hold,
  output logic            rd_ctrl,
  output logic            wr_thr,
  output logic            wr_ctrl,
  output logic            rd_rhr,
  output logic            rd_stat
);

  logic strobe_q;
  logic strobe_rise;

  always_ff @(posedge clk or negedge clear_n) begin
    if (!clear_n) strobe_q <= 1'b0;
    else          strobe_q <= strobe;
  end

  assign selected    = &cs;
  assign strobe_rise = strobe & ~strobe_q;

  // combinational read routing, no strobe needed
  assign rd_hold = selected & rd_wr & ~reg_sel;
  assign rd_ctrl = selected & rd_wr & reg_sel;

  // one event per strobe rising edge
  assign wr_thr  = strobe_rise & selected & ~rd_wr & ~reg_sel;
  assign wr_ctrl = strobe_rise & selected & ~rd_wr & reg_sel;
  assign rd_rhr  = strobe_rise & rd_hold;
  assign rd_stat = strobe_rise & rd_ctrl;

endmodule

// File: rtl/uart_ctrl_reg.sv
module uart_ctrl_reg
  import uart_reg_pkg::*;
(
  input  logic             clk,
  input  logic             clear_n,
  input  logic             wr_ctrl,
  input  logic [BUS_W-1:0] wdata,
  output ctrl_t            ctrl,
  output logic             tr_rise
);

  ctrl_t ctrl_q;

  always_ff @(posedge clk or negedge clear_n) begin
    if (!clear_n)     ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_after_write(ctrl_q, wdata);
  end

  assign ctrl    = ctrl_q;
  assign tr_rise = wr_ctrl & wdata[BUS_W-1] & ~ctrl_q.tx_req;

endmodule

// File: rtl/uart_stat_reg.sv
module uart_stat_reg
  import uart_reg_pkg::*;
(
  input  logic             clk,
  input  logic             clear_n,
  input  logic             wr_thr,
  input  logic             rd_rhr,
  input  logic             rd_stat,
  input  logic [BUS_W-1:0] wdata,
  input  logic             tx_take,
  input  logic             tx_shift_empty,
  input  logic             rx_valid,
  input  logic [BUS_W-1:0] rx_byte,
  input  logic             rx_perr,
  input  logic             rx_ferr,
  input  logic             tx_req,
  input  logic             rx_irq_en,
  input  logic             tr_rise,
  output stat_t            stat,
  output logic [BUS_W-1:0] rhr,
  output logic [BUS_W-1:0] thr,
  output logic             thr_full,
  output logic             irq_set,
  output logic             irq_pend
);

  logic             rdy_q, ovr_q, perr_q, ferr_q;
  logic             full_q, pend_q, tsre_q;
  logic [BUS_W-1:0] rhr_q, thr_q;
  logic             tsre_rise, thr_drain, rx_evt, tx_evt, irq_clr;

  assign tsre_rise = tx_shift_empty & ~tsre_q;
  assign thr_drain = tx_take & ~wr_thr;
  assign rx_evt    = rx_valid & rx_irq_en;
  assign tx_evt    = (tx_req & (thr_drain | (tsre_rise & ~full_q)))
                   | (tr_rise & ~full_q);
  assign irq_set   = rx_evt | tx_evt;
  assign irq_clr   = rd_stat | wr_thr;

  // receive side
  always_ff @(posedge clk or negedge clear_n) begin
    if (!clear_n) begin
      rhr_q  <= '0;
      rdy_q  <= 1'b0;
      ovr_q  <= 1'b0;
      perr_q <= 1'b0;
      ferr_q <= 1'b0;
    end else begin
      if (rx_valid) begin
        rhr_q  <= rx_byte;
        rdy_q  <= 1'b1;
        perr_q <= rx_perr;
        ferr_q <= rx_ferr;
      end else if (rd_rhr) begin
        rdy_q <= 1'b0;
      end
      if (rx_valid && rdy_q && !rd_rhr) ovr_q <= 1'b1;
      else if (rd_stat)                 ovr_q <= 1'b0;
    end
  end

  // transmit holding side
  always_ff @(posedge clk or negedge clear_n) begin
    if (!clear_n) begin
      thr_q  <= '0;
      full_q <= 1'b0;
      tsre_q <= 1'b1;
    end else begin
      tsre_q <= tx_shift_empty;
      if (wr_thr) begin
        thr_q  <= wdata;
        full_q <= 1'b1;
      end else if (tx_take) begin
        full_q <= 1'b0;
      end
    end
  end

  // interrupt: a new event wins over a release in the same cycle
  always_ff @(posedge clk or negedge clear_n) begin
    if (!clear_n)     pend_q <= 1'b0;
    else if (irq_set) pend_q <= 1'b1;
    else if (irq_clr) pend_q <= 1'b0;
  end

  always_comb begin
    stat             = '0;
    stat.shift_empty = tx_shift_empty;
    stat.thr_empty   = ~full_q;
    stat.ferr        = ferr_q;
    stat.perr        = perr_q;
    stat.ovr         = ovr_q;
    stat.rdy         = rdy_q;
  end

  assign rhr      = rhr_q;
  assign thr      = thr_q;
  assign thr_full = full_q;
  assign irq_pend = pend_q;

endmodule

// File: rtl/uart_cpu_regs.sv
module uart_cpu_regs
  import uart_reg_pkg::*;
#(
  parameter int CS_N = 3
) (
  input  logic            clk,
  input  logic            clear_n,
  input  logic [CS_N-1:0] cs,
  input  logic            reg_sel,
  input  logic            rd_wr,
  input  logic            strobe,
  input  logic [7:0]      wdata,
  output logic [7:0]      rdata,
  output logic [7:0]      thr_data,
  output logic            thr_full,
  input  logic            tx_take,
  input  logic            tx_shift_empty,
  input  logic            tx_serial,
  input  logic            rx_valid,
  input  logic [7:0]      rx_byte,
  input  logic            rx_perr,
  input  logic            rx_ferr,
  output logic [3:0]      data_bits,
  output logic            par_en,
  output logic            par_even,
  output logic            two_stop,
  output logic            rts_n,
  output logic            irq_n,
  output logic            sdo
);

  // named internal events, also used by the checker
  logic             selected, rd_hold, rd_ctrl;
  logic             wr_thr, wr_ctrl, rd_rhr, rd_stat;
  logic             tr_rise, irq_set, irq_pend;
  ctrl_t            ctrl;
  stat_t            stat;
  logic [BUS_W-1:0] rhr;

  uart_bus_decode #(.CS_N(CS_N)) u_dec (
    .clk      (clk),
    .clear_n  (clear_n),
    .cs       (cs),
    .reg_sel  (reg_sel),
    .rd_wr    (rd_wr),
    .strobe   (strobe),
    .selected (selected),
    .rd_hold  (rd_hold),
    .rd_ctrl  (rd_ctrl),
    .wr_thr   (wr_thr),
    .wr_ctrl  (wr_ctrl),
    .rd_rhr   (rd_rhr),
    .rd_stat  (rd_stat)
  );

  uart_ctrl_reg u_ctrl (
    .clk     (clk),
    .clear_n (clear_n),
    .wr_ctrl (wr_ctrl),
    .wdata   (wdata),
    .ctrl    (ctrl),
    .tr_rise (tr_rise)
  );

  uart_stat_reg u_stat (
    .clk            (clk),
    .clear_n        (clear_n),
    .wr_thr         (wr_thr),
    .rd_rhr         (rd_rhr),
    .rd_stat        (rd_stat),
    .wdata          (wdata),
    .tx_take        (tx_take),
    .tx_shift_empty (tx_shift_empty),
    .rx_valid       (rx_valid),
    .rx_byte        (rx_byte),
    .rx_perr        (rx_perr),
    .rx_ferr        (rx_ferr),
    .tx_req         (ctrl.tx_req),
    .rx_irq_en      (ctrl.rx_irq_en),
    .tr_rise        (tr_rise),
    .stat           (stat),
    .rhr            (rhr),
    .thr            (thr_data),
    .thr_full       (thr_full),
    .irq_set        (irq_set),
    .irq_pend       (irq_pend)
  );

  always_comb begin
    if (rd_ctrl)      rdata = stat;
    else if (rd_hold) rdata = rhr;
    else              rdata = '0;
  end

  assign data_bits = data_bits_of(ctrl.wlen);
  assign par_en    = ctrl.par_en;
  assign par_even  = ctrl.par_even;
  assign two_stop  = ctrl.two_stop;
  assign rts_n     = ~ctrl.tx_req;
  assign irq_n     = ~irq_pend;
  assign sdo       = ~clear_n | (~ctrl.brk & tx_serial);

endmodule

// File: rtl/uart_cpu_regs_chk.sv
module uart_cpu_regs_chk (
  input logic       clk,
  input logic       clear_n,
  input logic       selected,
  input logic       wr_thr,
  input logic       wr_ctrl,
  input logic       rd_rhr,
  input logic       rd_stat,
  input logic       irq_set,
  input logic [7:0] wdata,
  input logic [3:0] data_bits,
  input logic       par_en,
  input logic       par_even,
  input logic       two_stop,
  input logic [7:0] thr_data,
  input logic       thr_full,
  input logic       rts_n,
  input logic       irq_n
);

  // R2
  decode_onehot_chk: assert property (@(posedge clk) disable iff (!clear_n)
    $onehot0({wr_thr, wr_ctrl, rd_rhr, rd_stat}));

  // R1
  unselected_hold_chk: assert property (@(posedge clk) disable iff (!clear_n)
    !selected |=> ($stable(data_bits) && $stable(thr_data)));

  // R3
  wlen_load_chk: assert property (@(posedge clk) disable iff (!clear_n)
    (wr_ctrl && !wdata[7]) |=> (data_bits == (4'd5 + {2'b00, $past(wdata[1:0])})));

  // R4
  tr_keep_fmt_chk: assert property (@(posedge clk) disable iff (!clear_n)
    (wr_ctrl && wdata[7]) |=> $stable({data_bits, par_en, par_even, two_stop}));

  // R5
  rts_on_chk: assert property (@(posedge clk) disable iff (!clear_n)
    (wr_ctrl && wdata[7]) |=> !rts_n);

  // R5
  rts_off_chk: assert property (@(posedge clk) disable iff (!clear_n)
    (wr_ctrl && !wdata[7]) |=> rts_n);

  // R11
  irq_raise_chk: assert property (@(posedge clk) disable iff (!clear_n)
    irq_set |=> !irq_n);

  // R11
  irq_release_chk: assert property (@(posedge clk) disable iff (!clear_n)
    ((rd_stat || wr_thr) && !irq_set) |=> irq_n);

  // R12
  thr_load_chk: assert property (@(posedge clk) disable iff (!clear_n)
    wr_thr |=> (thr_full && thr_data == $past(wdata)));

endmodule

bind uart_cpu_regs uart_cpu_regs_chk u_chk (
  .clk       (clk),
  .clear_n   (clear_n),
  .selected  (selected),
  .wr_thr    (wr_thr),
  .wr_ctrl   (wr_ctrl),
  .rd_rhr    (rd_rhr),
  .rd_stat   (rd_stat),
  .irq_set   (irq_set),
  .wdata     (wdata),
  .data_bits (data_bits),
  .par_en    (par_en),
  .par_even  (par_even),
  .two_stop  (two_stop),
  .thr_data  (thr_data),
  .thr_full  (thr_full),
  .rts_n     (rts_n),
  .irq_n     (irq_n)
);

// File: tb/test_uart_cpu_regs.sv
module test_uart_cpu_regs;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {wdata, expected data bits, par_en, par_even, two_stop, break}
  localparam logic [15:0] FMT_VEC [NVEC] = '{
    {8'h00, 4'd5, 4'b0000},
    {8'h07, 4'd8, 4'b1000},
    {8'h0D, 4'd6, 4'b1100},
    {8'h12, 4'd7, 4'b0010},
    {8'h20, 4'd5, 4'b0001},
    {8'h5F, 4'd8, 4'b1110}
  };

  logic       clk = 1'b0;
  logic       clear_n = 1'b0;
  logic [2:0] cs = 3'b000;
  logic       reg_sel = 1'b0, rd_wr = 1'b0, strobe = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata, thr_data, rx_byte = 8'h00;
  logic       thr_full, tx_take = 1'b0, tx_shift_empty = 1'b1, tx_serial = 1'b1;
  logic       rx_valid = 1'b0, rx_perr = 1'b0, rx_ferr = 1'b0;
  logic [3:0] data_bits;
  logic       par_en, par_even, two_stop, rts_n, irq_n, sdo;
  int         checks = 0, failures = 0;
  bit         done = 1'b0;
  logic [7:0] r;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_cpu_regs i_uart_cpu_regs (
    .clk(clk), .clear_n(clear_n), .cs(cs), .reg_sel(reg_sel), .rd_wr(rd_wr),
    .strobe(strobe), .wdata(wdata), .rdata(rdata), .thr_data(thr_data),
    .thr_full(thr_full), .tx_take(tx_take), .tx_shift_empty(tx_shift_empty),
    .tx_serial(tx_serial), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .data_bits(data_bits),
    .par_en(par_en), .par_even(par_even), .two_stop(two_stop),
    .rts_n(rts_n), .irq_n(irq_n), .sdo(sdo)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // one strobed access; read data sampled before the edge
  task automatic bus(input logic [2:0] c, input logic rs, input logic rw,
                     input logic [7:0] d, output logic [7:0] rd);
    @(negedge clk);
    cs = c; reg_sel = rs; rd_wr = rw; wdata = d; strobe = 1'b1;
    #1 rd = rdata;
    @(negedge clk);
    strobe = 1'b0; cs = 3'b000;
  endtask

  task automatic rx_push(input logic [7:0] b, input logic pe, input logic fe);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b; rx_perr = pe; rx_ferr = fe;
    @(negedge clk);
    rx_valid = 1'b0; rx_perr = 1'b0; rx_ferr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 check("R8 sdo high in clear", sdo, 1);
    clear_n = 1'b1;
    // R8 reset state
    check("R8 rts_n", rts_n, 1);
    check("R8 irq_n", irq_n, 1);
    check("R8 data_bits", data_bits, 5);
    check("R8 thr_full", thr_full, 0);
    bus(3'b111, 1'b1, 1'b1, 8'h00, r);
    check("R6 status after clear", r, 8'hC0);

    // R3 R9 format table
    for (int i = 0; i < NVEC; i++) begin
      bus(3'b111, 1'b1, 1'b0, FMT_VEC[i][15:8], r);
      check("R3 R9 format", {data_bits, par_en, par_even, two_stop, ~sdo},
            FMT_VEC[i][7:0]);
      check("R3 rts_n high", rts_n, 1);
    end

    // receive path
    bus(3'b111, 1'b1, 1'b0, 8'h43, r);
    rx_push(8'h5A, 1'b0, 1'b0);
    check("R11 rx irq", irq_n, 0);
    bus(3'b111, 1'b1, 1'b1, 8'h00, r);
    check("R6 status ready", r, 8'hC1);
    check("R11 status read releases", irq_n, 1);
    bus(3'b111, 1'b0, 1'b1, 8'h00, r);
    check("R2 rhr read", r, 8'h5A);
    bus(3'b111, 1'b1, 1'b1, 8'h00, r);
    check("R10 ready cleared", r, 8'hC0);

    rx_push(8'h11, 1'b0, 1'b0);
    rx_push(8'h22, 1'b0, 1'b0);
    bus(3'b111, 1'b1, 1'b1, 8'h00, r);
    check("R10 overrun", r, 8'hC3);
    bus(3'b111, 1'b1, 1'b1, 8'h00, r);
    check("R10 overrun cleared", r, 8'hC1);
    bus(3'b111, 1'b0, 1'b1, 8'h00, r);
    check("R10 newest byte kept", r, 8'h22);

    rx_push(8'h33, 1'b1, 1'b1);
    bus(3'b111, 1'b1, 1'b1, 8'h00, r);
    check("R6 error bits", r, 8'hCD);
    bus(3'b111, 1'b0, 1'b1, 8'h00, r);
    bus(3'b111, 1'b1, 1'b1, 8'h00, r);
    check("R10 errors persist", r, 8'hCC);
    rx_push(8'h44, 1'b0, 1'b0);
    bus(3'b111, 1'b1, 1'b1, 8'h00, r);
    check("R10 errors follow byte", r, 8'hC1);

    // coincident delivery and receive read
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = 8'h55;
    cs = 3'b111; reg_sel = 1'b0; rd_wr = 1'b1; strobe = 1'b1;
    #1 r = rdata;
    @(negedge clk);
    rx_valid = 1'b0; strobe = 1'b0; cs = 3'b000;
    check("R10 coincident read old", r, 8'h44);
    bus(3'b111, 1'b1, 1'b1, 8'h00, r);
    check("R10 coincident no overrun", r, 8'hC1);
    bus(3'b111, 1'b0, 1'b1, 8'h00, r);
    check("R10 coincident new byte", r, 8'h55);

    // coincident delivery and status read: set wins
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = 8'h66;
    cs = 3'b111; reg_sel = 1'b1; rd_wr = 1'b1; strobe = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; strobe = 1'b0; cs = 3'b000;
    check("R11 set wins", irq_n, 0);
    bus(3'b111, 1'b1, 1'b1, 8'h00, r);
    bus(3'b111, 1'b0, 1'b1, 8'h00, r);

    // transmit request
    check("R5 rts idle", rts_n, 1);
    bus(3'b111, 1'b1, 1'b0, 8'h80, r);
    check("R5 rts asserted", rts_n, 0);
    check("R11 tr with empty thr", irq_n, 0);
    check("R4 format kept", data_bits, 8);
    bus(3'b111, 1'b0, 1'b0, 8'h3C, r);
    check("R11 thr write releases", irq_n, 1);
    check("R12 thr full", thr_full, 1);
    check("R12 thr data", thr_data, 8'h3C);
    @(negedge clk);
    tx_take = 1'b1; tx_shift_empty = 1'b0;
    @(negedge clk);
    tx_take = 1'b0;
    check("R12 take empties", thr_full, 0);
    check("R11 thr drained", irq_n, 0);
    bus(3'b111, 1'b1, 1'b1, 8'h00, r);
    check("R6 shift busy", r, 8'h40);
    @(negedge clk);
    tx_shift_empty = 1'b1;
    @(negedge clk);
    check("R11 shift empty rise", irq_n, 0);
    bus(3'b111, 1'b1, 1'b1, 8'h00, r);

    // take and write in one cycle
    bus(3'b111, 1'b0, 1'b0, 8'h11, r);
    @(negedge clk);
    cs = 3'b111; reg_sel = 1'b0; rd_wr = 1'b0; wdata = 8'h22; strobe = 1'b1;
    tx_take = 1'b1;
    @(negedge clk);
    strobe = 1'b0; cs = 3'b000; tx_take = 1'b0;
    check("R12 coincident full", thr_full, 1);
    check("R12 coincident data", thr_data, 8'h22);
    check("R11 no drain irq", irq_n, 1);

    // long strobe: one access only
    @(negedge clk);
    cs = 3'b111; reg_sel = 1'b0; rd_wr = 1'b0; wdata = 8'hA1; strobe = 1'b1;
    @(negedge clk);
    wdata = 8'hB2;
    @(negedge clk);
    wdata = 8'hC3;
    @(negedge clk);
    strobe = 1'b0; cs = 3'b000;
    check("R7 first data only", thr_data, 8'hA1);

    // request write keeps break clear
    bus(3'b111, 1'b1, 1'b0, 8'hA0, r);
    check("R4 break unchanged", sdo, 1);
    bus(3'b111, 1'b1, 1'b0, 8'h43, r);
    check("R5 rts released", rts_n, 1);

    // partial select
    bus(3'b110, 1'b1, 1'b0, 8'h00, r);
    check("R1 ctrl untouched", data_bits, 8);
    bus(3'b011, 1'b0, 1'b0, 8'h99, r);
    check("R1 thr untouched", thr_data, 8'hA1);
    bus(3'b101, 1'b1, 1'b1, 8'h00, r);
    check("R1 read bus idle", r, 8'h00);

    // break and serial pass-through
    bus(3'b111, 1'b1, 1'b0, 8'h00, r);
    @(negedge clk);
    tx_serial = 1'b0;
    #1 check("R9 follow low", sdo, 0);
    tx_serial = 1'b1;
    #1 check("R9 follow high", sdo, 1);

    // clear mid-run
    bus(3'b111, 1'b1, 1'b0, 8'h23, r);
    bus(3'b111, 1'b1, 1'b0, 8'h80, r);
    rx_push(8'h77, 1'b0, 1'b0);
    @(negedge clk);
    clear_n = 1'b0;
    #1 check("R8 sdo forced high", sdo, 1);
    @(negedge clk);
    clear_n = 1'b1;
    check("R8 rts after clear", rts_n, 1);
    check("R8 irq after clear", irq_n, 1);
    check("R8 format after clear", data_bits, 5);
    check("R8 thr empty", thr_full, 0);
    bus(3'b111, 1'b1, 1'b1, 8'h00, r);
    check("R8 status after clear", r, 8'hC0);
    bus(3'b111, 1'b0, 1'b1, 8'h00, r);
    check("R8 rhr after clear", r, 8'h00);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule